// File: doc/BRIEF.md
# Programmable Bank Clock Divider

This block takes one fast source clock and derives four divided clocks from it: three output banks (A, B and C, each driving a group of identical lanes) and one feedback output that is meant to be routed back to a frequency-locking loop. Every path has its own table of even division ratios, chosen by a small select code. A global rate select either keeps the table as listed (full rate) or doubles every ratio of every path (half rate). The upper half of the bank C lanes can be inverted, so that they run 180 degrees out of phase with the lower half.

An active-low reset doubles as the output enable. While it is low, every output is held low, the valid flag is low and all divider state is cleared. The rate select, the bank selects and the inversion select are captured only while reset is low and are frozen while the block runs. After release, a small controller goes from the hold state through a launch state into the run state. At the launch step all dividers start together, so the first rising edges of all paths coincide with the rise of the valid flag. Controller states: HOLD (reset low, configuration captured), LAUNCH (one cycle, dividers armed), RUN (outputs live). Transitions: HOLD to LAUNCH when reset is seen high, LAUNCH to RUN unconditionally, and any state to HOLD when reset is seen low.

Top module: `bankdiv_top`

## Requirements
- R1: Bank A ratio for select code 0,1,2,3 is 4,6,8,12 source cycles with rate_full=1 and 8,12,16,24 with rate_full=0.
- R2: Bank B ratio for select code 0,1,2,3 is 4,6,8,10 with rate_full=1 and 8,12,16,20 with rate_full=0.
- R3: Bank C ratio for select code 0,1,2,3 is 2,4,6,8 with rate_full=1 and 4,8,12,16 with rate_full=0.
- R4: Feedback ratio for the 3-bit code 0..7 is 4,6,8,10,8,12,16,20 with rate_full=1, and twice that with rate_full=0.
- R5: Each output stays high for exactly half its ratio and low for the other half (50% duty).
- R6: With inv_c_hi=1, bank C lanes LANES/2 and above are the complement of the lower lanes while running; with inv_c_hi=0 all bank C lanes are equal.
- R7: While rst_oe_n is low, after the first clock edge all outputs and q_valid are 0; after rst_oe_n is seen high, q_valid rises on the second clock edge.
- R8: Changes on rate_full, the select inputs or inv_c_hi while running do not alter any output until the next reset.
- R9: In the first cycle with q_valid high, qa, qb, the lower bank C lanes and qfb are all high.
- R10: All lanes within bank A, within bank B, and within each half of bank C carry the same value at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_oe_n | input | 1 | Active-low synchronous reset and output enable |
| rate_full | input | 1 | 1: ratios as listed, 0: all ratios doubled |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| sel_c | input | 2 | Bank C ratio code |
| sel_fb | input | 3 | Feedback ratio code |
| inv_c_hi | input | 1 | 1: invert upper bank C lanes |
| qa | output | LANES | Bank A clocks |
| qb | output | LANES | Bank B clocks |
| qc | output | LANES | Bank C clocks |
| qfb | output | 1 | Feedback clock |
| q_valid | output | 1 | Outputs enabled (stands in for the tristate control) |

## Verification
The assertions take for granted that rst_oe_n is low from time zero through at least one rising edge and that every input changes away from the rising edge, so reset release and configuration capture are clean. The stimulus keeps to this by driving every input on the falling edge and holding reset for three edges before each case. Select changes are only made while running or during reset, never in the single edge of release, and the checks for R8 compare against the configuration captured before the change.

// File: rtl/bankdiv_pkg.sv
package bankdiv_pkg;

    localparam int NBANK    = 4;
    localparam int IDX_A    = 0;
    localparam int IDX_B    = 1;
    localparam int IDX_C    = 2;
    localparam int IDX_FB   = 3;
    localparam int HALF_MAX = 20;
    localparam int CNT_W    = $clog2(HALF_MAX);

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_RUN    = 2'd2
    } phase_e;

    typedef struct packed {
        logic       rate_full;
        logic [1:0] sel_a;
        logic [1:0] sel_b;
        logic [1:0] sel_c;
        logic [2:0] sel_fb;
        logic       inv_c;
    } cfg_t;

    // Half period, in source cycles, of one path for a given code.
    function automatic logic [CNT_W-1:0] half_count(input int bank,
                                                    input logic [2:0] code,
                                                    input logic rate_full);
        int base;
        base = 2;
        case (bank)
            IDX_A:   base = (code[1:0] == 2'd3) ? 6 : int'(code[1:0]) + 2;
            IDX_B:   base = int'(code[1:0]) + 2;
            IDX_C:   base = int'(code[1:0]) + 1;
            default: base = code[2] ? 2 * (int'(code[1:0]) + 2)
                                    : int'(code[1:0]) + 2;
        endcase
        if (!rate_full) begin
            base = 2 * base;
        end
        return CNT_W'(base);
    endfunction

endpackage

// File: rtl/bankdiv_fsm.sv
module bankdiv_fsm
    import bankdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_oe_n,
    output logic div_en,
    output logic out_valid
);

    phase_e state;
    phase_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_oe_n) begin
            state <= ST_HOLD;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = ST_HOLD;
        unique case (state)
            ST_HOLD:   nxt = ST_LAUNCH;
            ST_LAUNCH: nxt = ST_RUN;
            ST_RUN:    nxt = ST_RUN;
            default:   nxt = ST_HOLD;
        endcase
    end

    always_comb begin
        div_en    = 1'b0;
        out_valid = 1'b0;
        unique case (state)
            ST_HOLD: begin
                div_en    = 1'b0;
                out_valid = 1'b0;
            end
            ST_LAUNCH: begin
                div_en    = 1'b1;
                out_valid = 1'b0;
            end
            ST_RUN: begin
                div_en    = 1'b1;
                out_valid = 1'b1;
            end
            default: begin
                div_en    = 1'b0;
                out_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bankdiv_cfg.sv
module bankdiv_cfg
    import bankdiv_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_oe_n,
    input  logic                        rate_full,
    input  logic [1:0]                  sel_a,
    input  logic [1:0]                  sel_b,
    input  logic [1:0]                  sel_c,
    input  logic [2:0]                  sel_fb,
    input  logic                        inv_c_hi,
    output logic [NBANK-1:0][CNT_W-1:0] half,
    output logic                        inv_c
);

    cfg_t held;

    // Configuration is captured only while reset is held low.
    always_ff @(posedge clk) begin
        if (!rst_oe_n) begin
            held.rate_full <= rate_full;
            held.sel_a     <= sel_a;
            held.sel_b     <= sel_b;
            held.sel_c     <= sel_c;
            held.sel_fb    <= sel_fb;
            held.inv_c     <= inv_c_hi;
        end
    end

    always_comb begin
        half[IDX_A]  = half_count(IDX_A,  {1'b0, held.sel_a}, held.rate_full);
        half[IDX_B]  = half_count(IDX_B,  {1'b0, held.sel_b}, held.rate_full);
        half[IDX_C]  = half_count(IDX_C,  {1'b0, held.sel_c}, held.rate_full);
        half[IDX_FB] = half_count(IDX_FB, held.sel_fb,        held.rate_full);
    end

    assign inv_c = held.inv_c;

endmodule

// File: rtl/bankdiv_cell.sv
module bankdiv_cell #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_oe_n,
    input  logic             en,
    input  logic [CNT_W-1:0] half,
    output logic             q
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last = half - CNT_W'(1);

    // Parked at the terminal count so the first enabled edge raises q.
    always_ff @(posedge clk) begin
        if (!rst_oe_n || !en) begin
            cnt <= last;
            q   <= 1'b0;
        end else if (cnt == last) begin
            cnt <= '0;
            q   <= ~q;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/bankdiv_top.sv
module bankdiv_top
    import bankdiv_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk_src,
    input  logic             rst_oe_n,
    input  logic             rate_full,
    input  logic [1:0]       sel_a,
    input  logic [1:0]       sel_b,
    input  logic [1:0]       sel_c,
    input  logic [2:0]       sel_fb,
    input  logic             inv_c_hi,
    output logic [LANES-1:0] qa,
    output logic [LANES-1:0] qb,
    output logic [LANES-1:0] qc,
    output logic             qfb,
    output logic             q_valid
);

    localparam int INV_FROM = LANES / 2;

    logic                        div_en;
    logic                        run;
    logic                        inv_c;
    logic [NBANK-1:0][CNT_W-1:0] half;
    logic [NBANK-1:0]            div_q;

    bankdiv_fsm u_fsm (
        .clk       (clk_src),
        .rst_oe_n  (rst_oe_n),
        .div_en    (div_en),
        .out_valid (run)
    );

    bankdiv_cfg u_cfg (
        .clk       (clk_src),
        .rst_oe_n  (rst_oe_n),
        .rate_full (rate_full),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .sel_c     (sel_c),
        .sel_fb    (sel_fb),
        .inv_c_hi  (inv_c_hi),
        .half      (half),
        .inv_c     (inv_c)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_path
        bankdiv_cell #(.CNT_W(CNT_W)) u_cell (
            .clk      (clk_src),
            .rst_oe_n (rst_oe_n),
            .en       (div_en),
            .half     (half[g]),
            .q        (div_q[g])
        );
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign qa[l] = run & div_q[IDX_A];
        assign qb[l] = run & div_q[IDX_B];
        if (l >= INV_FROM) begin : g_inv
            assign qc[l] = run & (div_q[IDX_C] ^ inv_c);
        end else begin : g_dir
            assign qc[l] = run & div_q[IDX_C];
        end
    end

    assign qfb     = run & div_q[IDX_FB];
    assign q_valid = run;

endmodule

// File: rtl/bankdiv_chk.sv
module bankdiv_chk #(
    parameter int LANES = 4
) (
    input logic             clk_src,
    input logic             rst_oe_n,
    input logic [LANES-1:0] qa,
    input logic [LANES-1:0] qb,
    input logic [LANES-1:0] qc,
    input logic             qfb,
    input logic             q_valid
);

    localparam int LO_N = LANES / 2;
    localparam int HI_N = LANES - LO_N;

    bit prev_low;

    // R7: one edge after reset is seen low, everything is quiet.
    always_ff @(posedge clk_src) begin
        if (prev_low) begin
            a_r7_quiet_after_reset: assert (!q_valid && qa == '0 && qb == '0
                                            && qc == '0 && !qfb);
        end
        prev_low <= !rst_oe_n;
    end

    a_r9_aligned_launch: assert property (@(posedge clk_src) disable iff (!rst_oe_n)
        $rose(q_valid) |-> (qa[0] && qb[0] && qc[0] && qfb));

    a_r10_lanes_agree: assert property (@(posedge clk_src) disable iff (!rst_oe_n)
        ($countones(qa) == 0 || $countones(qa) == LANES) &&
        ($countones(qb) == 0 || $countones(qb) == LANES) &&
        ($countones(qc[LO_N-1:0]) == 0 || $countones(qc[LO_N-1:0]) == LO_N) &&
        ($countones(qc[LANES-1:LO_N]) == 0 || $countones(qc[LANES-1:LO_N]) == HI_N));

    a_r6_phase_fixed: assert property (@(posedge clk_src) disable iff (!rst_oe_n)
        (q_valid && $past(q_valid)) |->
        ((qc[0] ^ qc[LANES-1]) == $past(qc[0] ^ qc[LANES-1])));

    a_r1_min_half: assert property (@(posedge clk_src) disable iff (!rst_oe_n)
        ($past(q_valid) && q_valid && (qa[0] != $past(qa[0]))) |=> $stable(qa[0]));

    a_r2_min_half: assert property (@(posedge clk_src) disable iff (!rst_oe_n)
        ($past(q_valid) && q_valid && (qb[0] != $past(qb[0]))) |=> $stable(qb[0]));

    a_r4_min_half: assert property (@(posedge clk_src) disable iff (!rst_oe_n)
        ($past(q_valid) && q_valid && (qfb != $past(qfb))) |=> $stable(qfb));

endmodule

bind bankdiv_top bankdiv_chk #(.LANES(LANES)) u_chk (
    .clk_src  (clk_src),
    .rst_oe_n (rst_oe_n),
    .qa       (qa),
    .qb       (qb),
    .qc       (qc),
    .qfb      (qfb),
    .q_valid  (q_valid)
);

// File: tb/bankdiv_top_test.sv
module bankdiv_top_test;

    localparam int CLK_P = 10;
    localparam int LANES = 4;
    localparam int NOBS  = 90;

    logic             clk_src = 1'b0;
    logic             rst_oe_n = 1'b0;
    logic             rate_full = 1'b1;
    logic [1:0]       sel_a = 2'b11;
    logic [1:0]       sel_b = 2'b11;
    logic [1:0]       sel_c = 2'b11;
    logic [2:0]       sel_fb = 3'b111;
    logic             inv_c_hi = 1'b1;
    logic [LANES-1:0] qa, qb, qc;
    logic             qfb, q_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk_src = ~clk_src;

    bankdiv_top #(.LANES(LANES)) uut (
        .clk_src   (clk_src),
        .rst_oe_n  (rst_oe_n),
        .rate_full (rate_full),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .sel_c     (sel_c),
        .sel_fb    (sel_fb),
        .inv_c_hi  (inv_c_hi),
        .qa        (qa),
        .qb        (qb),
        .qc        (qc),
        .qfb       (qfb),
        .q_valid   (q_valid)
    );

    // Expected full ratios, straight from the requirement tables.
    function automatic int ratio_a(input logic [1:0] c, input bit full);
        int r;
        case (c) 2'd0: r = 4; 2'd1: r = 6; 2'd2: r = 8; default: r = 12; endcase
        return full ? r : 2 * r;
    endfunction
    function automatic int ratio_b(input logic [1:0] c, input bit full);
        int r;
        case (c) 2'd0: r = 4; 2'd1: r = 6; 2'd2: r = 8; default: r = 10; endcase
        return full ? r : 2 * r;
    endfunction
    function automatic int ratio_c(input logic [1:0] c, input bit full);
        int r;
        case (c) 2'd0: r = 2; 2'd1: r = 4; 2'd2: r = 6; default: r = 8; endcase
        return full ? r : 2 * r;
    endfunction
    function automatic int ratio_fb(input logic [2:0] c, input bit full);
        int r;
        case (c)
            3'd0: r = 4;  3'd1: r = 6;  3'd2: r = 8;  3'd3: r = 10;
            3'd4: r = 8;  3'd5: r = 12; 3'd6: r = 16; default: r = 20;
        endcase
        return full ? r : 2 * r;
    endfunction

    function automatic bit wave(input int k, input int ratio);
        return ((k / (ratio / 2)) % 2) == 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_case(input bit full, input logic [1:0] a, input logic [1:0] b,
                            input logic [1:0] c, input logic [2:0] f,
                            input bit inv, input bit scr);
        int ra, rb, rc, rf;
        int ea, eb, ec, ef, ei, el, hi_run;
        bit hi_done;
        ra = ratio_a(a, full);
        rb = ratio_b(b, full);
        rc = ratio_c(c, full);
        rf = ratio_fb(f, full);
        ea = 0; eb = 0; ec = 0; ef = 0; ei = 0; el = 0; hi_run = 0; hi_done = 1'b0;
        @(negedge clk_src);
        rst_oe_n  = 1'b0;
        rate_full = full;
        sel_a = a; sel_b = b; sel_c = c; sel_fb = f; inv_c_hi = inv;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk_src);
            // R7: quiet while in reset
            check("R7 quiet in reset", {q_valid, qfb, qa, qb, qc}, 0);
        end
        rst_oe_n = 1'b1;
        @(negedge clk_src);
        check("R7 valid low one edge after release", int'(q_valid), 0);
        @(negedge clk_src);
        check("R7 valid high two edges after release", int'(q_valid), 1);
        // R9: aligned launch
        check("R9 aligned first edge", {qa[0], qb[0], qc[0], qfb}, 4'b1111);
        for (int k = 0; k < NOBS; k++) begin
            if (qa[0] != wave(k, ra)) ea++;
            if (qb[0] != wave(k, rb)) eb++;
            if (qc[0] != wave(k, rc)) ec++;
            if (qfb   != wave(k, rf)) ef++;
            if (qc[LANES-1] != (wave(k, rc) ^ inv)) ei++;
            if (qa != {LANES{qa[0]}} || qb != {LANES{qb[0]}} ||
                qc[LANES/2-1:0] != {(LANES/2){qc[0]}} ||
                qc[LANES-1:LANES/2] != {(LANES-LANES/2){qc[LANES-1]}}) el++;
            if (!hi_done) begin
                if (qfb) hi_run++;
                else hi_done = 1'b1;
            end
            if (scr && k == 7) begin
                rate_full = $urandom;
                sel_a = $urandom; sel_b = $urandom; sel_c = $urandom;
                sel_fb = $urandom; inv_c_hi = $urandom;
            end
            @(negedge clk_src);
        end
        check("R1 bank A waveform mismatches", ea, 0);
        check("R2 bank B waveform mismatches", eb, 0);
        check("R3 bank C waveform mismatches", ec, 0);
        check("R4 feedback waveform mismatches", ef, 0);
        check("R5 feedback high time", hi_run, rf / 2);
        check("R6 upper bank C phase mismatches", ei, 0);
        check("R10 lane disagreement count", el, 0);
        if (scr) begin
            check("R8 mismatches after select change", ea + eb + ec + ef + ei, 0);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        // Reset state from time zero
        repeat (2) @(negedge clk_src);
        check("R7 reset state at start", {q_valid, qfb, qa, qb, qc}, 0);
        // Default tie-high configuration
        run_case(1'b1, 2'b11, 2'b11, 2'b11, 3'b111, 1'b1, 1'b0);
        // Every code of every table, both rates
        for (int v = 0; v < 2; v++) begin
            for (int code = 0; code < 8; code++) begin
                run_case(v[0], code[1:0], code[1:0], code[1:0], code[2:0],
                         code[0], 1'b0);
            end
        end
        // Random configurations, half with select changes while running
        for (int n = 0; n < 16; n++) begin
            run_case($urandom, $urandom, $urandom, $urandom, $urandom,
                     $urandom, n[0]);
        end
        // Reset asserted mid-run
        @(negedge clk_src);
        rst_oe_n = 1'b0;
        @(negedge clk_src);
        check("R7 quiet after mid-run reset", {q_valid, qfb, qa, qb, qc}, 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule